// File: doc/BRIEF.md
# FIFO Status Interrupt Controller

This block gathers the status of a serial peripheral's transmit and receive FIFOs, together with a chip-select release event, into a single interrupt line. Two sources follow the FIFO levels directly. One asserts while the transmit FIFO is empty. The other asserts while the receive FIFO holds more entries than a programmable threshold. The remaining sources are sticky latches that one-cycle event pulses set: transmit overflow, receive underflow, receive overflow and chip-select inactive.

Software reaches the block through a simple register port. Each write is a single strobe with an address and data. Reads are combinational on the address. The readable registers are the raw status, an enable mask, the masked status and the receive threshold. A separate clear register uses its own bit layout to release the latched events one by one or all together. The interrupt output is high whenever any masked status bit is set.

Register addresses are 0 for the mask (read/write), 1 for the raw status (read-only), 2 for the masked status (read-only), 3 for the clear register (write-only, reads 0) and 4 for the threshold (read/write). Unused addresses read 0.

Top module: `fifo_irq_ctrl`

## Requirements
- R1: After reset the mask, the threshold and every event latch are 0, and the interrupt output is low.
- R2: Status bit 0 is 1 exactly while the transmit level is 0. Bit 5 always reads 0.
- R3: Status bit 4 is 1 exactly while the receive level is strictly greater than the threshold register at address 4. When the level equals the threshold, the bit stays 0.
- R4: A one-cycle pulse on transmit overflow, receive underflow, receive overflow or chip-select inactive sets status bit 1, 2, 3 or 6 respectively. The bit reads as set from the cycle after the pulse and holds until it is cleared.
- R5: Writing the clear register at address 3 with bit 1 set clears status bit 2. Bit 2 of the clear register clears status bit 3, and bit 3 clears status bit 1. Other latched bits are untouched.
- R6: Clear-register bit 0 clears all four latched bits, including chip-select inactive. Writing all ones has the same effect.
- R7: If an event pulse and a clear of the same bit arrive in the same cycle, the bit ends up set.
- R8: The mask at address 0 reads back as written. The masked status at address 2 equals the raw status at address 1 ANDed with the mask.
- R9: The interrupt output is the OR of the masked status bits. A mask of 0 holds it low and leaves the raw status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 3 | Register address for reads and writes |
| reg_wdata | input | BUS_W (7) | Write data |
| reg_rdata | output | BUS_W (7) | Read data for reg_addr, combinational |
| tx_level | input | LVL_W (6) | Transmit FIFO fill level |
| rx_level | input | LVL_W (6) | Receive FIFO fill level |
| ev_tx_ovf | input | 1 | Transmit overflow pulse |
| ev_rx_unf | input | 1 | Receive underflow pulse |
| ev_rx_ovf | input | 1 | Receive overflow pulse |
| ev_cs_inactive | input | 1 | Chip-select released pulse |
| irq | output | 1 | Interrupt, OR of masked status |

## Verification
The properties assume that event inputs are single-cycle pulses sampled on the clock, and that FIFO levels change only between clock edges. They also assume a write strobe carries a stable address and data for its cycle. The stimulus drives every input on the falling edge and drops each pulse and strobe after one cycle. It keeps the levels at or below the FIFO depth, and it raises an event together with a clear only in the deliberate same-cycle collision cases.

// File: rtl/fifo_irq_pkg.sv
package fifo_irq_pkg;
    localparam int NUM_BITS   = 7;
    localparam int ADDR_W     = 3;

    // status bit positions
    localparam int ST_TX_EMPTY = 0;
    localparam int ST_TX_OVF   = 1;
    localparam int ST_RX_UNF   = 2;
    localparam int ST_RX_OVF   = 3;
    localparam int ST_RX_ABOVE = 4;
    localparam int ST_CS_OFF   = 6;

    // clear register bit positions
    localparam int CL_ALL    = 0;
    localparam int CL_RX_UNF = 1;
    localparam int CL_RX_OVF = 2;
    localparam int CL_TX_OVF = 3;

    // latched event index
    localparam int NUM_EV  = 4;
    localparam int EV_TXO  = 0;
    localparam int EV_RXU  = 1;
    localparam int EV_RXO  = 2;
    localparam int EV_CS   = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_MASK   = 3'd0,
        A_RAW    = 3'd1,
        A_MASKED = 3'd2,
        A_CLEAR  = 3'd3,
        A_THRESH = 3'd4
    } reg_addr_e;

    function automatic int ev_status_pos(input int ev);
        case (ev)
            EV_TXO:  return ST_TX_OVF;
            EV_RXU:  return ST_RX_UNF;
            EV_RXO:  return ST_RX_OVF;
            default: return ST_CS_OFF;
        endcase
    endfunction
endpackage

// File: rtl/fifo_irq_evt_latch.sv
module fifo_irq_evt_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (clr_i) flag_d = 1'b0;
        if (set_i) flag_d = 1'b1;   // event has priority over clear
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/fifo_irq_cfg_regs.sv
module fifo_irq_cfg_regs
    import fifo_irq_pkg::*;
#(
    parameter int LVL_W = 6,
    parameter int BUS_W = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [BUS_W-1:0]    reg_wdata,
    output logic [NUM_BITS-1:0] mask_o,
    output logic [LVL_W-1:0]    thr_o,
    output logic [NUM_EV-1:0]   clr_o
);
    typedef struct packed {
        logic [NUM_BITS-1:0] mask;
        logic [LVL_W-1:0]    thr;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic clr_wr;

    always_comb begin
        cfg_d  = cfg_q;
        clr_wr = 1'b0;
        if (reg_wr) begin
            case (reg_addr)
                A_MASK:   cfg_d.mask = reg_wdata[NUM_BITS-1:0];
                A_THRESH: cfg_d.thr  = reg_wdata[LVL_W-1:0];
                A_CLEAR:  clr_wr     = 1'b1;
                default:  ;
            endcase
        end
        clr_o         = '0;
        clr_o[EV_TXO] = clr_wr && (reg_wdata[CL_ALL] || reg_wdata[CL_TX_OVF]);
        clr_o[EV_RXU] = clr_wr && (reg_wdata[CL_ALL] || reg_wdata[CL_RX_UNF]);
        clr_o[EV_RXO] = clr_wr && (reg_wdata[CL_ALL] || reg_wdata[CL_RX_OVF]);
        clr_o[EV_CS]  = clr_wr &&  reg_wdata[CL_ALL];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign mask_o = cfg_q.mask;
    assign thr_o  = cfg_q.thr;
endmodule

// File: rtl/fifo_irq_level_src.sv
module fifo_irq_level_src #(
    parameter int LVL_W = 6
) (
    input  logic [LVL_W-1:0] tx_level,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] thr,
    output logic             tx_empty_o,
    output logic             rx_above_o
);
    always_comb begin
        tx_empty_o = (tx_level == '0);
        rx_above_o = (rx_level > thr);   // strict comparison
    end
endmodule

// File: rtl/fifo_irq_ctrl.sv
module fifo_irq_ctrl
    import fifo_irq_pkg::*;
#(
    parameter  int FIFO_DEPTH = 32,
    localparam int LVL_W = $clog2(FIFO_DEPTH + 1),
    localparam int BUS_W = (LVL_W > NUM_BITS) ? LVL_W : NUM_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [BUS_W-1:0]  reg_wdata,
    output logic [BUS_W-1:0]  reg_rdata,
    input  logic [LVL_W-1:0]  tx_level,
    input  logic [LVL_W-1:0]  rx_level,
    input  logic              ev_tx_ovf,
    input  logic              ev_rx_unf,
    input  logic              ev_rx_ovf,
    input  logic              ev_cs_inactive,
    output logic              irq
);
    logic [NUM_BITS-1:0] mask_q;
    logic [LVL_W-1:0]    thr_q;
    logic [NUM_EV-1:0]   ev_clr;
    logic [NUM_EV-1:0]   ev_set;
    logic [NUM_EV-1:0]   ev_flag;
    logic                tx_empty, rx_above;
    logic [NUM_BITS-1:0] raw_status;
    logic [NUM_BITS-1:0] masked_status;

    fifo_irq_cfg_regs #(.LVL_W(LVL_W), .BUS_W(BUS_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .mask_o    (mask_q),
        .thr_o     (thr_q),
        .clr_o     (ev_clr)
    );

    fifo_irq_level_src #(.LVL_W(LVL_W)) u_lvl (
        .tx_level   (tx_level),
        .rx_level   (rx_level),
        .thr        (thr_q),
        .tx_empty_o (tx_empty),
        .rx_above_o (rx_above)
    );

    assign ev_set[EV_TXO] = ev_tx_ovf;
    assign ev_set[EV_RXU] = ev_rx_unf;
    assign ev_set[EV_RXO] = ev_rx_ovf;
    assign ev_set[EV_CS]  = ev_cs_inactive;

    for (genvar gi = 0; gi < NUM_EV; gi++) begin : g_latch
        fifo_irq_evt_latch u_latch (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (ev_set[gi]),
            .clr_i  (ev_clr[gi]),
            .flag_o (ev_flag[gi])
        );
    end

    always_comb begin
        raw_status              = '0;
        raw_status[ST_TX_EMPTY] = tx_empty;
        raw_status[ST_RX_ABOVE] = rx_above;
        for (int i = 0; i < NUM_EV; i++) begin
            raw_status[ev_status_pos(i)] = ev_flag[i];
        end
        masked_status = raw_status & mask_q;
        irq           = |masked_status;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_MASK:   reg_rdata[NUM_BITS-1:0] = mask_q;
            A_RAW:    reg_rdata[NUM_BITS-1:0] = raw_status;
            A_MASKED: reg_rdata[NUM_BITS-1:0] = masked_status;
            A_THRESH: reg_rdata[LVL_W-1:0]    = thr_q;
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/fifo_irq_ctrl_chk.sv
module fifo_irq_ctrl_chk
    import fifo_irq_pkg::*;
#(
    parameter  int FIFO_DEPTH = 32,
    localparam int LVL_W = $clog2(FIFO_DEPTH + 1),
    localparam int BUS_W = (LVL_W > NUM_BITS) ? LVL_W : NUM_BITS
) (
    input logic                clk,
    input logic                rst_n,
    input logic                reg_wr,
    input logic [ADDR_W-1:0]   reg_addr,
    input logic [BUS_W-1:0]    reg_wdata,
    input logic [LVL_W-1:0]    tx_level,
    input logic [LVL_W-1:0]    rx_level,
    input logic                ev_tx_ovf,
    input logic                ev_rx_unf,
    input logic                ev_rx_ovf,
    input logic                ev_cs_inactive,
    input logic [NUM_BITS-1:0] raw_status,
    input logic [LVL_W-1:0]    thr_q,
    input logic                irq
);
    logic clr_wr;
    assign clr_wr = reg_wr && (reg_addr == A_CLEAR);

    // R2
    tx_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_level != '0) |-> !raw_status[ST_TX_EMPTY]);

    // R3
    rx_thresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_level <= thr_q) |-> !raw_status[ST_RX_ABOVE]);

    // R4
    tx_ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_tx_ovf |=> raw_status[ST_TX_OVF]);

    // R7
    rx_ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_rx_ovf |=> raw_status[ST_RX_OVF]);

    // R4
    cs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_status[ST_CS_OFF] && !(clr_wr && reg_wdata[CL_ALL])) |=> raw_status[ST_CS_OFF]);

    // R5
    unf_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && reg_wdata[CL_RX_UNF] && !ev_rx_unf) |=> !raw_status[ST_RX_UNF]);

    // R6
    cs_clrall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && reg_wdata[CL_ALL] && !ev_cs_inactive) |=> !raw_status[ST_CS_OFF]);

    // R9
    mask_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_MASK && reg_wdata == '0) |=> !irq);
endmodule

bind fifo_irq_ctrl fifo_irq_ctrl_chk #(.FIFO_DEPTH(FIFO_DEPTH)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .reg_wr         (reg_wr),
    .reg_addr       (reg_addr),
    .reg_wdata      (reg_wdata),
    .tx_level       (tx_level),
    .rx_level       (rx_level),
    .ev_tx_ovf      (ev_tx_ovf),
    .ev_rx_unf      (ev_rx_unf),
    .ev_rx_ovf      (ev_rx_ovf),
    .ev_cs_inactive (ev_cs_inactive),
    .raw_status     (raw_status),
    .thr_q          (thr_q),
    .irq            (irq)
);

// File: tb/fifo_irq_ctrl_tb.sv
module fifo_irq_ctrl_tb;
    localparam int LVL_W = 6;
    localparam int BUS_W = 7;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             reg_wr = 1'b0;
    logic [2:0]       reg_addr = '0;
    logic [BUS_W-1:0] reg_wdata = '0;
    logic [BUS_W-1:0] reg_rdata;
    logic [LVL_W-1:0] tx_level = 6'd5;
    logic [LVL_W-1:0] rx_level = '0;
    logic ev_tx_ovf = 1'b0, ev_rx_unf = 1'b0, ev_rx_ovf = 1'b0, ev_cs_inactive = 1'b0;
    logic irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [BUS_W-1:0] data;
        logic             irq;
        string            tag;
    } exp_t;

    exp_t exp_q[$];
    event sample_ev;

    always #5 clk = ~clk;

    fifo_irq_ctrl #(.FIFO_DEPTH(32)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_level(tx_level), .rx_level(rx_level),
        .ev_tx_ovf(ev_tx_ovf), .ev_rx_unf(ev_rx_unf), .ev_rx_ovf(ev_rx_ovf),
        .ev_cs_inactive(ev_cs_inactive), .irq(irq)
    );

    // monitor: pops one expected item per sample event and compares
    initial begin
        forever begin
            @(sample_ev);
            while (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                checks++;
                if (reg_rdata !== e.data || irq !== e.irq) begin
                    errors++;
                    $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b",
                             e.tag, reg_rdata, irq, e.data, e.irq);
                end
            end
        end
    end

    task automatic check(input logic [2:0] a, input logic [BUS_W-1:0] d,
                         input logic i, input string tag);
        exp_t e;
        @(negedge clk);
        reg_addr = a;
        #2;
        e.data = d; e.irq = i; e.tag = tag;
        exp_q.push_back(e);
        -> sample_ev;
    endtask

    task automatic write_reg(input logic [2:0] a, input logic [BUS_W-1:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    // events: bit0 tx_ovf, bit1 rx_unf, bit2 rx_ovf, bit3 cs_inactive; optional clear in same cycle
    task automatic pulse(input logic [3:0] ev, input bit do_clr, input logic [BUS_W-1:0] clr);
        @(negedge clk);
        {ev_cs_inactive, ev_rx_ovf, ev_rx_unf, ev_tx_ovf} = ev;
        if (do_clr) begin
            reg_wr = 1'b1; reg_addr = 3'd3; reg_wdata = clr;
        end
        @(negedge clk);
        {ev_cs_inactive, ev_rx_ovf, ev_rx_unf, ev_tx_ovf} = '0;
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check(3'd1, 7'h00, 1'b0, "R1 raw");
        check(3'd0, 7'h00, 1'b0, "R1 mask");
        check(3'd4, 7'h00, 1'b0, "R1 thresh");

        // R2: transmit empty level bit
        @(negedge clk); tx_level = '0;
        check(3'd1, 7'h01, 1'b0, "R2 tx empty");
        // R8 / R9
        write_reg(3'd0, 7'h5F);
        check(3'd0, 7'h5F, 1'b1, "R8 mask readback");
        check(3'd2, 7'h01, 1'b1, "R8 masked");
        @(negedge clk); tx_level = 6'd3;
        check(3'd1, 7'h00, 1'b0, "R2 tx not empty");

        // R3: strict threshold
        write_reg(3'd4, 7'd3);
        check(3'd4, 7'd3, 1'b0, "R3 thresh readback");
        @(negedge clk); rx_level = 6'd3;
        check(3'd1, 7'h00, 1'b0, "R3 level equal");
        @(negedge clk); rx_level = 6'd4;
        check(3'd1, 7'h10, 1'b1, "R3 level above");
        @(negedge clk); rx_level = 6'd0;

        // R4: sticky latches
        pulse(4'b0001, 0, '0);
        check(3'd1, 7'h02, 1'b1, "R4 tx ovf");
        pulse(4'b0010, 0, '0);
        check(3'd1, 7'h06, 1'b1, "R4 rx unf");
        pulse(4'b0100, 0, '0);
        check(3'd1, 7'h0E, 1'b1, "R4 rx ovf");
        pulse(4'b1000, 0, '0);
        check(3'd1, 7'h4E, 1'b1, "R4 cs inactive");
        repeat (3) @(negedge clk);
        check(3'd1, 7'h4E, 1'b1, "R4 hold");

        // R5: individual clears
        write_reg(3'd3, 7'h02);
        check(3'd1, 7'h4A, 1'b1, "R5 clear rx unf");
        write_reg(3'd3, 7'h04);
        check(3'd1, 7'h42, 1'b1, "R5 clear rx ovf");
        write_reg(3'd3, 7'h08);
        check(3'd1, 7'h40, 1'b1, "R5 clear tx ovf");

        // R6: clear all
        write_reg(3'd3, 7'h01);
        check(3'd1, 7'h00, 1'b0, "R6 clear-all bit");
        pulse(4'b1111, 0, '0);
        check(3'd1, 7'h4E, 1'b1, "R6 all set");
        write_reg(3'd3, 7'h7F);
        check(3'd1, 7'h00, 1'b0, "R6 all ones");

        // R7: event wins over clear
        pulse(4'b0100, 1, 7'h04);
        check(3'd1, 7'h08, 1'b1, "R7 rx ovf vs clear");
        pulse(4'b1000, 1, 7'h01);
        check(3'd1, 7'h40, 1'b1, "R7 cs vs clear-all");

        // R8 / R9: masking
        pulse(4'b0100, 0, '0);
        check(3'd1, 7'h48, 1'b1, "R8 raw before mask");
        write_reg(3'd0, 7'h08);
        check(3'd2, 7'h08, 1'b1, "R8 masked subset");
        write_reg(3'd0, 7'h00);
        check(3'd2, 7'h00, 1'b0, "R9 mask zero");
        check(3'd1, 7'h48, 1'b0, "R9 raw kept");

        @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule